// File: doc/BRIEF.md
# Programmable-Timing SRAM Bus Sequencer

This block runs single accesses on an asynchronous external SRAM bus that is split into several chip-select areas. A requester presents an area number, an address, write data and a direction with a one-cycle start pulse. The sequencer then lowers the chip select of that area and waits out a setup phase. It pulses the read or write strobe for a programmable width, keeps chip select low for a programmable hold phase, and finally reports completion with a one-cycle done pulse that carries the read data.

Each area gets its own timing byte inside one 32-bit configuration word. A byte holds a 2-bit setup count, a 2-bit hold count and a 4-bit static wait count. The sequencer copies the selected byte when it accepts a request, so software may rewrite the word at any time without disturbing an access that is in flight. Only one access is outstanding at a time, and a busy output tells the requester when a new start pulse will be taken.

Top module: `sram_seq_top`

## Requirements
- R1: After reset the configuration word reads 0xFFFFFFFF. All chip selects and both strobes are high (inactive), busy is low and done is low.
- R2: Chip select of the addressed area stays low for exactly setup+1 cycles before the strobe falls, where setup is the 2-bit field in bits [7:6] of that area's byte.
- R3: The strobe is low for exactly 1+wait cycles, where wait is the 4-bit field in bits [3:0] of the area's byte, taken without offset.
- R4: After the strobe rises, chip select stays low for exactly hold+1 cycles, where hold is the field in bits [5:4] of the area's byte.
- R5: Area k takes its timing from bits [8k+7:8k] of the configuration word. A write to the word is read back unchanged in the bits that belong to areas.
- R6: With three areas, bits [31:24] read as 1 and writes to them have no effect.
- R7: For a read, rdData holds the sramDin value present in the last cycle of the read strobe. The done pulse comes in the cycle right after the last hold cycle, and chip select is already high in that cycle.
- R8: A write uses the write strobe only. The read strobe stays high, and sramDoe is high with sramDout equal to the request data in every cycle from the first setup cycle to the last hold cycle.
- R9: Busy is high from the cycle after acceptance through the last hold cycle. A start pulse seen while busy is dropped and starts no second access.
- R10: The timing fields are captured at acceptance. A configuration write during an access does not change that access.
- R11: A start pulse naming an area number of 3 or more (with three areas) is ignored. No chip select falls and busy stays low.
- R12: Only the addressed area's chip select goes low during an access, and sramAddr equals the request address throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration word write enable |
| cfgWdata | input | 32 | Configuration word write value |
| cfgRdata | output | 32 | Configuration word read value |
| reqValid | input | 1 | Start pulse for an access |
| reqArea | input | 2 | Area number of the access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Captured read data |
| sramCeN | output | 3 | Active-low chip select, one per area |
| sramOeN | output | 1 | Active-low read strobe |
| sramWeN | output | 1 | Active-low write strobe |
| sramAddr | output | 16 | SRAM address |
| sramDout | output | 16 | SRAM write data |
| sramDoe | output | 1 | Write data output enable |
| sramDin | input | 16 | SRAM read data |

## Verification
The bench measures setup, strobe and hold lengths at every field extreme, including zero wait and the all-ones reset timing. A design with a missing off-by-one would come up one cycle short in setup or hold. The SRAM model returns a different value in each strobe cycle, so a design that samples one cycle early or late returns the wrong word. Directed cases rewrite the configuration and raise a second start pulse during an access, and send a start to a nonexistent area. A design that reads the live register would stretch or shrink the running access, and one without an idle check would launch a second access or drive a chip select for no area.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  // One area's timing byte: setup in [7:6], hold in [5:4], wait in [3:0]
  typedef struct packed {
    logic [1:0] setup;
    logic [1:0] hold;
    logic [3:0] waitCnt;
  } areaTiming_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;   // request taken this cycle
    logic active;   // chip select phase (setup, strobe, hold)
    logic strobe;   // read/write strobe phase
    logic capture;  // last strobe cycle
  } seqCtl_t;

endpackage

// File: rtl/sram_seq_cfg.sv
module sram_seq_cfg
  import sram_seq_pkg::*;
#(
  parameter int NUM_AREAS = 3,
  parameter int AREA_W    = 2,
  parameter int REG_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [REG_W-1:0]  cfgWdata,
  output logic [REG_W-1:0]  cfgRdata,
  input  logic [AREA_W-1:0] lookupArea,
  output areaTiming_t       lookupTiming
);

  localparam int BYTE_W = $bits(areaTiming_t);
  localparam int USED_W = NUM_AREAS * BYTE_W;

  logic [USED_W-1:0] cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '1;
    else if (cfgWe) cfgQ <= cfgWdata[USED_W-1:0];
  end

  generate
    if (USED_W < REG_W) begin : g_resv
      assign cfgRdata = {{(REG_W-USED_W){1'b1}}, cfgQ};
    end else begin : g_full
      assign cfgRdata = cfgQ;
    end
  endgenerate

  always_comb begin
    lookupTiming = '1;
    for (int k = 0; k < NUM_AREAS; k++) begin
      if (lookupArea == AREA_W'(k)) lookupTiming = areaTiming_t'(cfgQ[k*BYTE_W +: BYTE_W]);
    end
  end

  // R5
  cfg_write_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> cfgRdata[USED_W-1:0] == $past(cfgWdata[USED_W-1:0]));

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqAreaValid,
  input  areaTiming_t timing,
  output seqCtl_t     ctl,
  output logic        busy,
  output logic        done
);

  seqState_t  state;
  logic [3:0] cnt;
  logic [1:0] holdQ;
  logic [3:0] waitQ;
  logic       accept;

  assign accept = (state == ST_IDLE) && reqValid && reqAreaValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      holdQ <= '0;
      waitQ <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_SETUP;
            cnt   <= {2'b00, timing.setup};
            holdQ <= timing.hold;
            waitQ <= timing.waitCnt;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_STROBE;
            cnt   <= waitQ;
          end else cnt <= cnt - 4'd1;
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            state <= ST_HOLD;
            cnt   <= {2'b00, holdQ};
          end else cnt <= cnt - 4'd1;
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else cnt <= cnt - 4'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.accept  = accept;
    ctl.active  = (state != ST_IDLE);
    ctl.strobe  = (state == ST_STROBE);
    ctl.capture = (state == ST_STROBE) && (cnt == '0);
  end

  assign busy = ctl.active;

  // R7
  done_after_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(state) == ST_HOLD);

  // R10
  timing_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> ($stable(holdQ) && $stable(waitQ)));

  // R3
  strobe_count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE) |-> cnt <= waitQ);

endmodule

// File: rtl/sram_seq_dp.sv
module sram_seq_dp
  import sram_seq_pkg::*;
#(
  parameter int NUM_AREAS = 3,
  parameter int AREA_W    = 2,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [AREA_W-1:0] reqArea,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDin,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_AREAS-1:0] sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramDoe
);

  logic [AREA_W-1:0] areaQ;
  logic              writeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      areaQ    <= '0;
      writeQ   <= 1'b0;
      sramAddr <= '0;
      sramDout <= '0;
      rdData   <= '0;
    end else begin
      if (ctl.accept) begin
        areaQ    <= reqArea;
        writeQ   <= reqWrite;
        sramAddr <= reqAddr;
        sramDout <= reqWdata;
      end
      if (ctl.capture && !writeQ) rdData <= sramDin;
    end
  end

  generate
    for (genvar k = 0; k < NUM_AREAS; k++) begin : g_ce
      assign sramCeN[k] = !(ctl.active && (areaQ == AREA_W'(k)));
    end
  endgenerate

  assign sramOeN = !(ctl.strobe && !writeQ);
  assign sramWeN = !(ctl.strobe && writeQ);
  assign sramDoe = ctl.active && writeQ;

  // R8
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramOeN && !sramWeN));

  // R12
  single_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~sramCeN));

  // R2
  strobe_inside_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sramOeN || !sramWeN) |-> (~sramCeN != '0));

  // R12
  addr_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((~sramCeN != '0) && !ctl.accept) |=> $stable(sramAddr) || (~sramCeN == '0));

endmodule

// File: rtl/sram_seq_top.sv
module sram_seq_top
  import sram_seq_pkg::*;
#(
  parameter int NUM_AREAS = 3,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int REG_W     = 32,
  localparam int AREA_W   = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [REG_W-1:0]     cfgWdata,
  output logic [REG_W-1:0]     cfgRdata,
  input  logic                 reqValid,
  input  logic [AREA_W-1:0]    reqArea,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_AREAS-1:0] sramCeN,
  output logic                 sramOeN,
  output logic                 sramWeN,
  output logic [ADDR_W-1:0]    sramAddr,
  output logic [DATA_W-1:0]    sramDout,
  output logic                 sramDoe,
  input  logic [DATA_W-1:0]    sramDin
);

  areaTiming_t selTiming;
  seqCtl_t     ctl;
  logic        reqAreaValid;

  assign reqAreaValid = ({{(32-AREA_W){1'b0}}, reqArea} < 32'(NUM_AREAS));

  sram_seq_cfg #(.NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W), .REG_W(REG_W)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .lookupArea(reqArea), .lookupTiming(selTiming)
  );

  sram_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAreaValid(reqAreaValid),
    .timing(selTiming), .ctl(ctl), .busy(busy), .done(done)
  );

  sram_seq_dp #(.NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqArea(reqArea), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .sramDin(sramDin), .rdData(rdData),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN), .sramAddr(sramAddr),
    .sramDout(sramDout), .sramDoe(sramDoe)
  );

  // R11
  no_ce_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sramCeN == '1));

endmodule

// File: tb/sram_seq_top_tb.sv
module sram_seq_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        reqValid = 1'b0;
  logic [1:0]  reqArea = '0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        busy, done;
  logic [15:0] rdData;
  logic [2:0]  sramCeN;
  logic        sramOeN, sramWeN, sramDoe;
  logic [15:0] sramAddr, sramDout, sramDin;
  logic [3:0]  rdIdx = '0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] shadow = 32'hFFFF_FFFF;

  always #5 clk = ~clk;

  sram_seq_top u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .reqValid(reqValid), .reqArea(reqArea), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busy(busy), .done(done), .rdData(rdData), .sramCeN(sramCeN),
    .sramOeN(sramOeN), .sramWeN(sramWeN), .sramAddr(sramAddr), .sramDout(sramDout),
    .sramDoe(sramDoe), .sramDin(sramDin)
  );

  // SRAM model: returns a different word in each read strobe cycle
  always @(posedge clk) rdIdx <= sramOeN ? 4'd0 : rdIdx + 4'd1;
  assign sramDin = sramOeN ? 16'hDEAD : (sramAddr ^ {12'b0, rdIdx});

  function automatic int expSetup(logic [7:0] b); return int'(b[7:6]) + 1; endfunction
  function automatic int expWidth(logic [7:0] b); return int'(b[3:0]) + 1; endfunction
  function automatic int expHold(logic [7:0] b);  return int'(b[5:4]) + 1; endfunction
  function automatic logic [31:0] expRead(logic [31:0] w); return {8'hFF, w[23:0]}; endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeCfg(logic [31:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk); cfgWe = 1'b0;
    shadow = v;
  endtask

  // Runs one access; optionally rewrites config or pulses a second start mid-access
  task automatic runAccess(logic [1:0] area, logic [15:0] addr, logic [15:0] wd,
                           bit wr, bit midCfg, bit midReq);
    logic [7:0] tb = shadow[area*8 +: 8];
    int s = 0, w = 0, h = 0, bad = 0, badW = 0, badCe = 0;
    bit seen = 0, gotDone = 0;
    @(negedge clk);
    reqValid = 1'b1; reqArea = area; reqAddr = addr; reqWdata = wd; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    for (int it = 0; it < 100; it++) begin
      if (done) begin gotDone = 1; break; end
      if (it == 1 && midCfg) begin cfgWe = 1'b1; cfgWdata = 32'h0; end
      if (it == 2 && midCfg) cfgWe = 1'b0;
      if (it == 1 && midReq) begin
        reqValid = 1'b1; reqArea = area + 2'd1; reqAddr = ~addr; reqWrite = ~wr;
      end
      if (it == 2 && midReq) reqValid = 1'b0;
      if (!busy || sramCeN[area]) bad++;
      if ((sramCeN | (3'b1 << area)) != 3'b111) badCe++;
      if (sramAddr != addr) badCe++;
      if (wr && (!sramOeN || !sramDoe || sramDout != wd)) badW++;
      if (!wr && (!sramWeN || sramDoe)) badW++;
      if ((wr ? sramWeN : sramOeN) == 1'b0) begin w++; seen = 1; end
      else if (!seen) s++;
      else h++;
      @(negedge clk);
    end
    if (midCfg) shadow = 32'h0;
    check(gotDone, "R7 done", 32'(gotDone), 1);
    check(sramCeN == 3'b111, "R7 ce high at done", 32'(sramCeN), 32'h7);
    check(bad == 0, "R9 busy/ce during access", bad, 0);
    check(badCe == 0, "R12 ce/addr", badCe, 0);
    check(badW == 0, "R8 direction/data", badW, 0);
    check(s == expSetup(tb), "R2 setup", s, expSetup(tb));
    check(w == expWidth(tb), "R3 strobe width", w, expWidth(tb));
    check(h == expHold(tb), "R4 hold", h, expHold(tb));
    if (!wr) check(rdData == (addr ^ 16'(tb[3:0])), "R7 read data", rdData, addr ^ 16'(tb[3:0]));
    if (midCfg) check(1'b1 && s == expSetup(tb) && w == expWidth(tb), "R10 latched timing", w, expWidth(tb));
    @(negedge clk);
    check(!busy && sramCeN == 3'b111, "R9 no second access", 32'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cfgRdata == 32'hFFFF_FFFF, "R1 cfg reset", cfgRdata, 32'hFFFF_FFFF);
    check(sramCeN == 3'b111 && sramOeN && sramWeN, "R1 bus idle", {sramCeN, sramOeN, sramWeN}, 5'h1F);
    check(!busy && !done, "R1 busy/done", {busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 slowest default timing
    runAccess(2'd1, 16'h1234, 16'h0, 1'b0, 1'b0, 1'b0);
    // R5, R6 packing and reserved bits
    writeCfg(32'h1234_5678);
    check(cfgRdata == 32'hFF34_5678, "R6 reserved read as one", cfgRdata, 32'hFF34_5678);
    writeCfg(32'h00C3_2D00);
    check(cfgRdata == expRead(32'h00C3_2D00), "R5 readback", cfgRdata, expRead(32'h00C3_2D00));
    // R5 minimum timing in area 0, mixed in areas 1 and 2
    runAccess(2'd0, 16'hA5A5, 16'h0, 1'b0, 1'b0, 1'b0);
    runAccess(2'd1, 16'h0F0F, 16'hBEEF, 1'b1, 1'b0, 1'b0);
    runAccess(2'd2, 16'h7777, 16'h0, 1'b0, 1'b0, 1'b0);
    // R10 config rewritten mid-access; R9 start pulse while busy
    writeCfg(32'hFFFF_FFFF);
    runAccess(2'd0, 16'h4321, 16'h0, 1'b0, 1'b1, 1'b0);
    writeCfg(32'h0035_9A6C);
    runAccess(2'd2, 16'h1111, 16'h2222, 1'b1, 1'b0, 1'b1);
    runAccess(2'd0, 16'h3333, 16'h0, 1'b0, 1'b0, 1'b1);
    // R11 nonexistent area
    @(negedge clk);
    reqValid = 1'b1; reqArea = 2'd3; reqAddr = 16'h5555;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) begin
      check(!busy && sramCeN == 3'b111, "R11 bad area ignored", {busy, sramCeN}, 4'h7);
      @(negedge clk);
    end
    // Constrained random accesses
    for (int n = 0; n < 40; n++) begin
      if (n % 4 == 0) writeCfg($urandom);
      runAccess(2'($urandom_range(0, 2)), 16'($urandom), 16'($urandom),
                1'($urandom), 1'b0, 1'b0);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule